// File: doc/BRIEF.md
# Two-Level Hardware Page Walker with Translation Cache

This block turns 32-bit linear addresses into physical addresses through a small fully associative translation cache. When a lookup misses, a control state machine walks a two-level page table held in memory. It first reads an entry from the root table, whose physical base comes from a root-pointer register. It then reads an entry from a second-level table, unless the root entry maps a 4 MB page by itself. The resulting translation is installed in the cache. The requester stays stalled during the walk and keeps its request steady. When the refill is done, the same lookup hits.

Memory is reached through a word-read port that carries one request at a time. Each request is a single-cycle pulse, and the matching response returns some cycles later. A non-present entry at either level ends the walk with a one-cycle fault pulse that carries the faulting address, and no translation is installed. Writing the root pointer is how a context switch is made. That write drops every cached translation that is not marked global. A separate invalidate input removes the one translation that covers a given address, whether or not it is global.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the cache holds no valid translation, no memory read is pending and no fault is signalled.
- R2: On a miss, the first read goes to {root[31:12], va[31:22], 2'b00}. If that entry is present (bit 0) and its large bit (bit 7) is clear, a second read follows to {entry[31:12], va[21:12], 2'b00}.
- R3: After a 4 KB refill the lookup hits with physical address {leaf[31:12], va[11:0]} and attributes {global = bit 8, user = bit 2, writable = bit 1}. A later lookup of the same page hits in the same cycle and issues no memory read.
- R4: A present root entry with bit 7 set ends the walk after exactly one read. It maps a 4 MB page with physical address {root[31:22], va[21:0]}, reports the large flag, and covers every address that shares va[31:22].
- R5: A root or leaf entry with bit 0 clear gives a one-cycle fault pulse with faultAddr equal to the looked-up address, and no translation is installed, so a retry walks again.
- R6: While a lookup misses and no fault is signalled, lkStall is high. lkStall is never high in a cycle where lkHit is high.
- R7: A root-pointer write invalidates every translation whose global bit is clear and keeps those whose global bit is set.
- R8: An invalidate request clears the translation that covers invlAddr (compared on va[31:22] for a 4 MB page, on va[31:12] for a 4 KB page), even a global one, and leaves the other translations valid.
- R9: Refills fill the cache slots in round-robin order, so the ninth distinct refill after reset replaces the first translation installed.
- R10: At most one memory read is outstanding. memReqValid is a one-cycle pulse and is not raised again until the response to the previous read has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request, held while stalled |
| lkAddr | input | 32 | Linear address to translate |
| lkHit | output | 1 | Lookup hits a valid translation |
| lkStall | output | 1 | Lookup missed; requester must wait |
| lkPhys | output | 32 | Translated physical address |
| lkLarge | output | 1 | Hit translation is a 4 MB page |
| lkAttr | output | 3 | {global, user, writable} of the hit translation |
| faultValid | output | 1 | One-cycle page-fault pulse |
| faultAddr | output | 32 | Address that faulted |
| rootWr | input | 1 | Root-pointer write (context switch) |
| rootData | input | 32 | New root table base, bits [31:12] used |
| invlValid | input | 1 | Invalidate the translation covering invlAddr |
| invlAddr | input | 32 | Address to invalidate |
| memReqValid | output | 1 | One-cycle word-read request pulse |
| memReqAddr | output | 32 | Word-read address |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response word |

## Verification
A hit is visible through combinational logic in the cycle the address is applied. On a miss, the read request appears one cycle later. A response starts the next read one cycle after it arrives. A refill becomes a hit two cycles after the final response, and a fault pulse appears one cycle after the response that carries it. The memory model in the bench answers each read three cycles after the request. That gives fixed end points: a 4 KB hit on sample 8, a 4 MB hit on sample 5, a root fault on sample 4 and a leaf fault on sample 7, all counted from the cycle the lookup is applied. The bench samples at the falling edge and checks the outcome against the exact sample index, as well as against the logged read addresses.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int ADDR_W = 32;
  localparam int VPN_W  = 20;
  localparam int PTE_P  = 0;
  localparam int PTE_WR = 1;
  localparam int PTE_US = 2;
  localparam int PTE_LG = 7;
  localparam int PTE_GL = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_READ_ROOT, S_READ_LEAF, S_REFILL, S_FAULT
  } walkState_e;

  typedef struct packed {
    logic capVa;
    logic capPte;
    logic markBig;
    logic refill;
    logic leafSel;
  } walkCtl_t;
endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lkValid,
  input  logic     hit,
  input  logic     memRspValid,
  input  logic     rspPresent,
  input  logic     rspLarge,
  output walkCtl_t ctl,
  output logic     memReqValid,
  output logic     lkStall,
  output logic     faultValid
);
  walkState_e state, stateNext;
  logic issue;

  always_comb begin
    stateNext   = state;
    issue       = 1'b0;
    ctl         = '0;
    ctl.leafSel = (state == S_READ_LEAF);
    ctl.refill  = (state == S_REFILL);
    case (state)
      S_IDLE: if (lkValid && !hit) begin
        ctl.capVa = 1'b1;
        issue     = 1'b1;
        stateNext = S_READ_ROOT;
      end
      S_READ_ROOT: if (memRspValid) begin
        ctl.capPte = 1'b1;
        if (!rspPresent) stateNext = S_FAULT;
        else if (rspLarge) begin
          ctl.markBig = 1'b1;
          stateNext   = S_REFILL;
        end else begin
          issue     = 1'b1;
          stateNext = S_READ_LEAF;
        end
      end
      S_READ_LEAF: if (memRspValid) begin
        ctl.capPte = 1'b1;
        stateNext  = rspPresent ? S_REFILL : S_FAULT;
      end
      S_REFILL: stateNext = S_IDLE;
      S_FAULT:  stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      memReqValid <= 1'b0;
    end else begin
      state       <= stateNext;
      memReqValid <= issue;
    end
  end

  assign faultValid = (state == S_FAULT);
  assign lkStall    = lkValid && !hit && !faultValid;

  // R10: one read in flight, each request a single-cycle pulse
  a_r10_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  // R5: the fault indication lasts exactly one cycle
  a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> !faultValid);
  // R6: stall and hit never coincide (hit comes from the datapath)
  a_r6_stall_not_hit: assert property (@(posedge clk) disable iff (!rstN)
    lkStall |-> !hit);
endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              rootWr,
  input  logic [ADDR_W-1:0] rootData,
  input  logic              invlValid,
  input  logic [ADDR_W-1:0] invlAddr,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              hit,
  output logic [ADDR_W-1:0] lkPhys,
  output logic              lkLarge,
  output logic [2:0]        lkAttr,
  output logic [ADDR_W-1:0] vaQ,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              rspPresent,
  output logic              rspLarge
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] rootBase, pteFrame;
  logic             pteGlobal, bigQ;
  logic [1:0]       pteAttr;
  logic [IDX_W-1:0] rrPtr;
  logic [ENTRIES-1:0] hitVec;
  logic [VPN_W-1:0] pfnArr [ENTRIES];
  logic [2:0]       attArr [ENTRIES];
  logic [ENTRIES-1:0] bigArr;
  logic unusedBits;

  assign unusedBits = ^{memRspData[11:9], memRspData[6:3], rootData[11:0], invlAddr[11:0]};
  assign rspPresent = memRspData[PTE_P];
  assign rspLarge   = memRspData[PTE_LG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rootBase  <= '0;
      vaQ       <= '0;
      pteFrame  <= '0;
      pteGlobal <= 1'b0;
      pteAttr   <= '0;
      bigQ      <= 1'b0;
      rrPtr     <= '0;
    end else begin
      if (rootWr) rootBase <= rootData[31:12];
      if (ctl.capVa) begin
        vaQ  <= lkAddr;
        bigQ <= 1'b0;
      end
      if (ctl.markBig) bigQ <= 1'b1;
      if (ctl.capPte) begin
        pteFrame  <= memRspData[31:12];
        pteGlobal <= memRspData[PTE_GL];
        pteAttr   <= {memRspData[PTE_US], memRspData[PTE_WR]};
      end
      if (ctl.refill)
        rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  assign memReqAddr = ctl.leafSel ? {pteFrame, vaQ[21:12], 2'b00}
                                  : {rootBase, vaQ[31:22], 2'b00};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic             vld, big, glb;
    logic [VPN_W-1:0] vpn, pfn;
    logic [1:0]       att;
    logic             mine, invlHit;

    assign mine    = ctl.refill && (rrPtr == IDX_W'(i));
    assign invlHit = vld && (big ? (vpn[19:10] == invlAddr[31:22]) : (vpn == invlAddr[31:12]));
    assign hitVec[i] = vld && (big ? (vpn[19:10] == lkAddr[31:22]) : (vpn == lkAddr[31:12]));
    assign pfnArr[i] = pfn;
    assign attArr[i] = {glb, att};
    assign bigArr[i] = big;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld <= 1'b0; big <= 1'b0; glb <= 1'b0;
        vpn <= '0;   pfn <= '0;   att <= '0;
      end else if (mine) begin
        vld <= 1'b1;
        big <= bigQ;
        glb <= pteGlobal;
        vpn <= vaQ[31:12];
        pfn <= pteFrame;
        att <= pteAttr;
      end else if ((rootWr && !glb) || (invlValid && invlHit)) begin
        vld <= 1'b0;
      end
    end

    // R7: after a root write only global translations remain valid
    a_r7_global_survives: assert property (@(posedge clk) disable iff (!rstN)
      (rootWr && !mine) |=> (!vld || glb));
    // R8: an address invalidate removes the covering translation
    a_r8_invl_clears: assert property (@(posedge clk) disable iff (!rstN)
      (invlValid && invlHit && !mine) |=> !vld);
  end

  always_comb begin
    hit     = |hitVec;
    lkPhys  = '0;
    lkLarge = 1'b0;
    lkAttr  = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (hitVec[k]) begin
        lkLarge = bigArr[k];
        lkAttr  = attArr[k];
        lkPhys  = bigArr[k] ? {pfnArr[k][19:10], lkAddr[21:0]} : {pfnArr[k], lkAddr[11:0]};
      end
    end
  end

  // R9: refills never create two translations for one address
  a_r9_onehot_hits: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lkValid,
  input  logic [31:0] lkAddr,
  output logic        lkHit,
  output logic        lkStall,
  output logic [31:0] lkPhys,
  output logic        lkLarge,
  output logic [2:0]  lkAttr,
  output logic        faultValid,
  output logic [31:0] faultAddr,
  input  logic        rootWr,
  input  logic [31:0] rootData,
  input  logic        invlValid,
  input  logic [31:0] invlAddr,
  output logic        memReqValid,
  output logic [31:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData
);
  walkCtl_t ctl;
  logic hit, rspPresent, rspLarge;

  pgwalk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .hit(hit),
    .memRspValid(memRspValid), .rspPresent(rspPresent), .rspLarge(rspLarge),
    .ctl(ctl), .memReqValid(memReqValid), .lkStall(lkStall), .faultValid(faultValid)
  );

  pgwalk_dpath #(.ENTRIES(ENTRIES)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lkAddr(lkAddr),
    .rootWr(rootWr), .rootData(rootData), .invlValid(invlValid), .invlAddr(invlAddr),
    .memRspData(memRspData), .hit(hit), .lkPhys(lkPhys), .lkLarge(lkLarge),
    .lkAttr(lkAttr), .vaQ(faultAddr), .memReqAddr(memReqAddr),
    .rspPresent(rspPresent), .rspLarge(rspLarge)
  );

  assign lkHit = lkValid && hit;

  // R1: nothing is requested or signalled right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!memReqValid && !faultValid));
endmodule

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;
  logic clk = 0, rstN = 0;
  logic lkValid = 0, rootWr = 0, invlValid = 0, memRspValid = 0;
  logic [31:0] lkAddr = 0, rootData = 0, invlAddr = 0, memRspData = 0;
  logic lkHit, lkStall, lkLarge, faultValid, memReqValid;
  logic [31:0] lkPhys, faultAddr, memReqAddr;
  logic [2:0] lkAttr;

  int nChecks = 0, nFails = 0;
  logic [31:0] pt [int];
  int pendCnt = 0, reqCount = 0, overlapErr = 0;
  logic [31:0] pendAddr = 0;
  logic [31:0] logAddr [8];

  logic resHit, resFault, resLarge, stallBad;
  logic [31:0] resPhys, resFaultAddr;
  logic [2:0] resAttr;
  int resCycles;

  always #2 clk = ~clk;

  pgwalk_top u_pgwalk_top (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr), .lkHit(lkHit),
    .lkStall(lkStall), .lkPhys(lkPhys), .lkLarge(lkLarge), .lkAttr(lkAttr),
    .faultValid(faultValid), .faultAddr(faultAddr), .rootWr(rootWr), .rootData(rootData),
    .invlValid(invlValid), .invlAddr(invlAddr), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // memory model: answers each read three cycles after the request
  always @(negedge clk) begin
    memRspValid <= 1'b0;
    if (memReqValid) begin
      if (pendCnt > 0) overlapErr++;
      if (reqCount < 8) logAddr[reqCount] = memReqAddr;
      reqCount++;
      pendAddr = memReqAddr;
      pendCnt  = 2;
    end else if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        memRspValid <= 1'b1;
        memRspData  <= pt.exists(pendAddr) ? pt[pendAddr] : 32'h0;
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; lkValid = 0; rootWr = 0; invlValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic writeRoot(input logic [31:0] base);
    @(negedge clk); rootWr = 1; rootData = base;
    @(negedge clk); rootWr = 0;
  endtask

  task automatic invalidate(input logic [31:0] a);
    @(negedge clk); invlValid = 1; invlAddr = a;
    @(negedge clk); invlValid = 0;
  endtask

  task automatic translate(input logic [31:0] va);
    @(negedge clk); lkValid = 1; lkAddr = va; #1;
    reqCount = 0; resCycles = 0; resHit = 0; resFault = 0; stallBad = 0;
    for (int n = 0; n < 40; n++) begin
      if (lkHit) begin
        resHit = 1; resPhys = lkPhys; resAttr = lkAttr; resLarge = lkLarge;
        break;
      end
      if (faultValid) begin
        resFault = 1; resFaultAddr = faultAddr;
        break;
      end
      if (!lkStall) stallBad = 1;
      resCycles++;
      @(negedge clk); #1;
    end
    lkValid = 0;
  endtask

  task automatic testReset();
    doReset();
    check(!memReqValid && !faultValid, "R1 idle outputs", {30'b0, memReqValid, faultValid}, 0);
    lkValid = 1; lkAddr = 32'h0040_3ABC; #1;
    check(!lkHit, "R1 empty cache", lkHit, 0);
    lkValid = 0;
  endtask

  task automatic test4k();
    pt[32'h0010_0004] = 32'h0020_0001;
    pt[32'h0020_000C] = 32'h0ABC_D007;
    writeRoot(32'h0010_0000);
    translate(32'h0040_3ABC);
    check(reqCount == 2, "R2 two reads", reqCount, 2);
    check(logAddr[0] == 32'h0010_0004, "R2 root addr", logAddr[0], 32'h0010_0004);
    check(logAddr[1] == 32'h0020_000C, "R2 leaf addr", logAddr[1], 32'h0020_000C);
    check(resHit && resCycles == 8, "R3 hit on sample 8", resCycles, 8);
    check(resPhys == 32'h0ABC_DABC, "R3 phys", resPhys, 32'h0ABC_DABC);
    check(resAttr == 3'b011 && !resLarge, "R3 attr", {28'b0, resLarge, resAttr}, 3);
    check(!stallBad, "R6 stall during walk", stallBad, 0);
    translate(32'h0040_3004);
    check(resHit && resCycles == 0 && reqCount == 0, "R3 rehit no read", resCycles, 0);
    check(resPhys == 32'h0ABC_D004, "R3 rehit phys", resPhys, 32'h0ABC_D004);
  endtask

  task automatic test4m();
    pt[32'h0010_000C] = 32'h0F40_0083;
    translate(32'h00C1_2345);
    check(reqCount == 1, "R4 one read", reqCount, 1);
    check(resHit && resCycles == 5, "R4 hit on sample 5", resCycles, 5);
    check(resPhys == 32'h0F41_2345 && resLarge, "R4 phys", resPhys, 32'h0F41_2345);
    translate(32'h00F0_0010);
    check(resHit && resCycles == 0 && resPhys == 32'h0F70_0010, "R4 same 4MB page", resPhys, 32'h0F70_0010);
  endtask

  task automatic testFaults();
    translate(32'h0800_0000);
    check(resFault && resCycles == 4, "R5 root fault timing", resCycles, 4);
    check(resFaultAddr == 32'h0800_0000, "R5 fault addr", resFaultAddr, 32'h0800_0000);
    translate(32'h0800_0000);
    check(resFault && reqCount == 1, "R5 no install, rewalk", reqCount, 1);
    translate(32'h0040_5123);
    check(resFault && resCycles == 7 && resFaultAddr == 32'h0040_5123, "R5 leaf fault", resCycles, 7);
  endtask

  task automatic testFlush();
    pt[32'h0010_0014] = 32'h1E00_0181;
    translate(32'h0140_0000);
    check(resHit && resAttr[2], "R7 global installed", resAttr, 3'b100);
    writeRoot(32'h0010_0000);
    translate(32'h0140_0010);
    check(resHit && resCycles == 0 && resPhys == 32'h1E00_0010, "R7 global kept", resPhys, 32'h1E00_0010);
    translate(32'h0040_3ABC);
    check(resHit && reqCount == 2, "R7 non-global flushed", reqCount, 2);
    translate(32'h00C0_0000);
    check(resHit && reqCount == 1, "R7 large non-global flushed", reqCount, 1);
  endtask

  task automatic testInvl();
    invalidate(32'h0140_0004);
    translate(32'h0040_3ABC);
    check(resHit && resCycles == 0, "R8 other entry kept", resCycles, 0);
    translate(32'h0140_0000);
    check(resHit && reqCount == 1, "R8 global cleared", reqCount, 1);
  endtask

  task automatic testRoundRobin();
    doReset();
    pt.delete();
    writeRoot(32'h0010_0000);
    for (int d = 16; d < 25; d++) pt[32'h0010_0000 + d * 4] = (d << 22) | 32'h81;
    for (int d = 16; d < 25; d++) translate(d << 22);
    for (int d = 17; d < 25; d++) begin
      translate((d << 22) | 32'h10);
      check(resHit && resCycles == 0 && resPhys == ((d << 22) | 32'h10), "R9 kept entry", resPhys, (d << 22) | 32'h10);
    end
    translate(32'h0400_0000);
    check(resHit && reqCount == 1, "R9 oldest evicted", reqCount, 1);
    check(overlapErr == 0, "R10 single outstanding", overlapErr, 0);
  endtask

  initial begin
    testReset();
    test4k();
    test4m();
    testFaults();
    testFlush();
    testInvl();
    testRoundRobin();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog R1-all hung run actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule